// File: doc/BRIEF.md
# Serial Register-Access Target with Auto-Incrementing Pointer

This block is the target side of a two-wire serial bus (I2C-compatible, 7-bit addressing). It connects a bus controller to a small bank of byte-wide registers inside the chip. The clock and data lines come in raw. They pass through a synchroniser clocked by the system clock before the block looks for bus conditions. The block drives the data line only through an open-drain enable: a high enable pulls the line low. The block answers to one fixed device address. It keeps a byte-wide pointer that selects the register to access, and the pointer advances after every byte transferred.

In a write transaction, the byte after the device address loads the pointer. Each byte after that goes into the selected register. In a read transaction, the block streams the selected register and the ones after it for as long as the controller acknowledges.

Address 0x00 is a read-only status byte taken from an input, so a controller can poll it repeatedly after every stop. Addresses 1 to NUM_REGS-1 are writable control bytes, and their contents are exported to the rest of the chip. Every other address reads as zero and ignores writes.

Top module: `i2c_reg_target`

## Requirements
- R1: A falling SDA while SCL is high is a start condition. A rising SDA while SCL is high is a stop condition. A start is recognised in any state, including in the middle of a transaction (repeated start).
- R2: After a start, the block shifts in 8 bits MSB first, sampling on rising SCL. If the upper 7 bits equal DEV_ADDR (0x48, so bytes 0x90 and 0x91), it pulls SDA low for the ninth clock. Bit 0 = 0 selects write and bit 0 = 1 selects read.
- R3: If the device address does not match, the block never drives SDA until the next start condition.
- R4: In a write, the first byte after the device address loads the pointer and is acknowledged.
- R5: Each later write byte is stored into the register the pointer selects and acknowledged, and then the pointer increments by one. Registers that are not written keep their value.
- R6: A write to address 0x00 (read-only status) or to an address of NUM_REGS or above is discarded but still acknowledged.
- R7: In a read, the block sends the selected register MSB first. When the controller acknowledges, the pointer increments and the next register follows.
- R8: When the controller does not acknowledge a read byte, the block releases the bus and goes idle with the pointer unchanged. A later repeated-start read returns the same register.
- R9: Any stop condition returns the block to idle and clears the pointer to 0x00, so the next read returns the status input.
- R10: Reads from addresses of NUM_REGS or above return 0x00. The pointer wraps from 0xFF to 0x00.
- R11: The SDA drive enable changes only while SCL is low.
- R12: After reset, SDA is not driven and all control registers are 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired-AND value) |
| status_i | input | 8 | Byte returned for reads of address 0x00 |
| sda_oe | output | 1 | 1 pulls the data line low |
| ctrl_o | output | (NUM_REGS-1)*8 | Control registers; register k sits at bits [8(k-1)+7 : 8(k-1)] |

## Verification
The hardest case to reach is the pointer state left behind by a read that ends in a not-acknowledge. It can only be observed if no stop condition follows, because any stop clears the pointer. The bench therefore sets the pointer in a write and turns the bus around with a repeated start. It ends a read with a not-acknowledge, then issues another repeated start and reads again. The same byte must come back. Pointer wrap is reached by loading 0xFE and reading across the top of the address space without a stop.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_PTR,
        RX_DATA
    } rxkind_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_ch;
        logic [STAGES-1:0] sda_ch;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.scl_ch = {q.scl_ch[STAGES-2:0], scl_in};
        d.sda_ch = {q.sda_ch[STAGES-2:0], sda_in};
        d.scl_p  = q.scl_ch[STAGES-1];
        d.sda_p  = q.sda_ch[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o     = q.scl_ch[STAGES-1];
    assign sda_o     = q.sda_ch[STAGES-1];
    assign scl_rise  = scl_o & ~q.scl_p;
    assign scl_fall  = ~scl_o & q.scl_p;
    assign start_det = scl_o & q.scl_p & q.sda_p & ~sda_o;
    assign stop_det  = scl_o & q.scl_p & ~q.sda_p & sda_o;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NUM_REGS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [7:0]                rd_addr,
    input  logic [7:0]                status_i,
    output logic [7:0]                rd_data,
    output logic [(NUM_REGS-1)*8-1:0] ctrl_o
);

    localparam int CTRL_W = (NUM_REGS - 1) * 8;

    for (genvar k = 1; k < NUM_REGS; k++) begin : g_reg
        logic [7:0] r_q;
        logic [7:0] r_d;

        always_comb begin
            r_d = r_q;
            if (wr_en && wr_addr == 8'(k)) r_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= 8'h00;
            else        r_q <= r_d;
        end

        assign ctrl_o[(k-1)*8 +: 8] = r_q;
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == 8'h00) rd_data = status_i;
        for (int k = 1; k < NUM_REGS; k++) begin
            if (rd_addr == 8'(k)) rd_data = ctrl_o[(k-1)*8 +: 8];
        end
    end

    // R6: a write aimed at status or beyond the bank leaves every register as it was
    a_r6_invalid_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 8'h00 || {1'b0, wr_addr} >= 9'(NUM_REGS)))
            |=> $stable(ctrl_o));

    // R5: without a write strobe nothing in the bank moves
    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_o));

    initial begin
        if (CTRL_W < 8 || NUM_REGS > 256) $error("NUM_REGS out of range");
    end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    input  logic [7:0]                status_i,
    output logic                      sda_oe,
    output logic [(NUM_REGS-1)*8-1:0] ctrl_o
);

    localparam int         BITS_W   = 4;
    localparam logic [3:0] LAST_BIT = 4'(7);
    localparam logic [3:0] FULL     = 4'(8);

    typedef struct packed {
        phase_e            phase;
        rxkind_e           kind;
        logic [BITS_W-1:0] bits;
        logic [7:0]        shreg;
        logic              rd;
        logic [7:0]        ptr;
        logic              oe;
        logic              mack;
    } ctl_t;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    ctl_t q, d;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .status_i (status_i),
        .rd_data  (rd_data),
        .ctrl_o   (ctrl_o)
    );

    // the byte to send after a controller ACK is the one past the pointer
    assign rd_addr = (q.phase == PH_MACK) ? q.ptr + 8'd1 : q.ptr;
    assign wr_addr = q.ptr;
    assign wr_data = q.shreg;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (stop_det) begin
            d.phase = PH_IDLE;
            d.ptr   = 8'h00;
            d.oe    = 1'b0;
        end else if (start_det) begin
            d.phase = PH_RX;
            d.kind  = RX_DEV;
            d.bits  = '0;
            d.oe    = 1'b0;
        end else begin
            unique case (q.phase)
                PH_IDLE: ;
                PH_RX: begin
                    if (scl_rise && q.bits < FULL) begin
                        d.shreg = {q.shreg[6:0], sda_s};
                        d.bits  = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == FULL) begin
                        unique case (q.kind)
                            RX_DEV: begin
                                if (q.shreg[7:1] == DEV_ADDR) begin
                                    d.rd    = q.shreg[0];
                                    d.oe    = 1'b1;
                                    d.phase = PH_ACK;
                                end else begin
                                    d.phase = PH_IDLE;
                                end
                            end
                            RX_PTR: begin
                                d.ptr   = q.shreg;
                                d.oe    = 1'b1;
                                d.phase = PH_ACK;
                            end
                            default: begin
                                wr_en   = 1'b1;
                                d.ptr   = q.ptr + 8'd1;
                                d.oe    = 1'b1;
                                d.phase = PH_ACK;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.bits = '0;
                        if (q.kind == RX_DEV && q.rd) begin
                            d.phase = PH_TX;
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[7];
                        end else begin
                            d.phase = PH_RX;
                            d.kind  = (q.kind == RX_DEV) ? RX_PTR : RX_DATA;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.bits == LAST_BIT) begin
                            d.oe    = 1'b0;
                            d.phase = PH_MACK;
                        end else begin
                            d.bits  = q.bits + 1'b1;
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.ptr   = q.ptr + 8'd1;
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[7];
                            d.bits  = '0;
                            d.phase = PH_TX;
                        end else begin
                            d.phase = PH_IDLE;
                        end
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.kind  <= RX_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

    // R11: the drive enable moves only after SCL has been seen low (bus conditions excepted)
    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(stop_det) || $past(start_det)));

    // R1, R9: a stop leaves the block idle, released, pointer at zero
    a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.ptr == 8'h00 && !sda_oe && q.phase == PH_IDLE));

    // R8: a controller NACK keeps the pointer and releases the line
    a_r8_nack_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_MACK && scl_fall && !q.mack && !start_det && !stop_det)
            |=> (q.ptr == $past(q.ptr) && !sda_oe));

    // R3: the idle phase never drives the line
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && !start_det) |=> !sda_oe);

endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_REGS   = 8;
    localparam int QTR        = 6;
    localparam int CTRL_W     = (NUM_REGS - 1) * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic [7:0]        status = 8'hC3;
    logic              sda_oe;
    logic [CTRL_W-1:0] ctrl_o;
    logic              sda_bus;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  mon_en = 0;
    bit  quiet_win = 0;
    int  quiet_hits = 0;
    int  oe_hi_moves = 0;
    logic prev_oe = 1'b0;

    logic [7:0] m_regs [NUM_REGS];
    int         m_ptr = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_target #(.DEV_ADDR(7'h48), .NUM_REGS(NUM_REGS), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .status_i (status),
        .sda_oe   (sda_oe),
        .ctrl_o   (ctrl_o)
    );

    function automatic logic [CTRL_W-1:0] model_ctrl();
        logic [CTRL_W-1:0] v = '0;
        for (int k = 1; k < NUM_REGS; k++) v[(k-1)*8 +: 8] = m_regs[k];
        return v;
    endfunction

    function automatic logic [7:0] model_read();
        if (m_ptr == 0)        return status;
        if (m_ptr < NUM_REGS)  return m_regs[m_ptr];
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference comparison of the register bank and line rules
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_en) check(ctrl_o == model_ctrl(), "R5 ctrl vs model", ctrl_o, model_ctrl());
            if (sda_oe != prev_oe && scl_m) oe_hi_moves++;
            if (quiet_win && sda_oe) quiet_hits++;
        end
        prev_oe <= sda_oe;
    end

    task automatic qwait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; qwait();
            scl_m = 1'b1; qwait();
        end
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        m_ptr = 0;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus;  qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic dev_byte(input logic [7:0] v, input bit exp_ack, input string tag);
        logic ack;
        send_byte(v, ack);
        check(ack == exp_ack, tag, ack, exp_ack);
    endtask

    task automatic ptr_byte(input logic [7:0] v);
        logic ack;
        send_byte(v, ack);
        check(ack == 1'b1, "R4 pointer byte ack", ack, 1);
        m_ptr = v;
    endtask

    task automatic wr_byte(input logic [7:0] v, input string tag);
        logic ack;
        mon_en = 0;
        send_byte(v, ack);
        check(ack == 1'b1, tag, ack, 1);
        if (m_ptr >= 1 && m_ptr < NUM_REGS) m_regs[m_ptr] = v;
        m_ptr = (m_ptr + 1) % 256;
        mon_en = 1;
    endtask

    task automatic rd_byte(input bit mack, input string tag);
        logic [7:0] v;
        logic [7:0] e;
        e = model_read();
        recv_byte(mack, v);
        check(v == e, tag, v, e);
        if (mack) m_ptr = (m_ptr + 1) % 256;
    endtask

    initial begin
        for (int k = 0; k < NUM_REGS; k++) m_regs[k] = 8'h00;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R12 reset release", sda_oe, 0);
        check(ctrl_o == '0, "R12 reset ctrl", ctrl_o, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        mon_en = 1;

        // write burst: pointer 2, two data bytes
        bus_start();
        dev_byte(8'h90, 1, "R2 write address ack");
        ptr_byte(8'h02);
        wr_byte(8'hA5, "R5 data ack reg2");
        wr_byte(8'h3C, "R5 data ack reg3");
        bus_stop();

        // read after stop starts at status and streams on
        bus_start();
        dev_byte(8'h91, 1, "R2 read address ack");
        rd_byte(1, "R9 status after stop");
        rd_byte(1, "R7 reg1");
        rd_byte(1, "R7 reg2");
        rd_byte(0, "R7 reg3");
        bus_stop();

        // status polling with a new value
        status = 8'h5A;
        bus_start();
        dev_byte(8'h91, 1, "R2 read address ack poll");
        rd_byte(0, "R9 status poll");
        bus_stop();

        // NACK keeps pointer across repeated starts
        bus_start();
        dev_byte(8'h90, 1, "R2 write address ack");
        ptr_byte(8'h03);
        bus_start();
        dev_byte(8'h91, 1, "R1 repeated start read ack");
        rd_byte(0, "R8 first read reg3");
        bus_start();
        dev_byte(8'h91, 1, "R1 second repeated start ack");
        rd_byte(0, "R8 pointer unchanged after NACK");
        bus_stop();

        // foreign addresses stay silent
        quiet_win = 1;
        bus_start();
        dev_byte(8'hA0, 0, "R3 mismatch nack");
        dev_byte(8'h00, 0, "R3 no ack on later byte");
        bus_start();
        dev_byte(8'h93, 0, "R3 neighbour address nack");
        bus_stop();
        quiet_win = 0;
        check(quiet_hits == 0, "R3 line never driven", quiet_hits, 0);

        // invalid writes: status slot and beyond the bank
        bus_start();
        dev_byte(8'h90, 1, "R2 write address ack");
        ptr_byte(8'h00);
        wr_byte(8'h77, "R6 status write acked");
        bus_stop();
        bus_start();
        dev_byte(8'h91, 1, "R2 read address ack");
        rd_byte(0, "R6 status unchanged");
        bus_stop();
        bus_start();
        dev_byte(8'h90, 1, "R2 write address ack");
        ptr_byte(8'(NUM_REGS));
        wr_byte(8'h11, "R6 out of range write acked");
        bus_stop();
        check(ctrl_o == model_ctrl(), "R6 bank untouched", ctrl_o, model_ctrl());

        // out-of-range reads and pointer wrap
        bus_start();
        dev_byte(8'h90, 1, "R2 write address ack");
        ptr_byte(8'hFE);
        bus_start();
        dev_byte(8'h91, 1, "R1 repeated start read ack");
        rd_byte(1, "R10 read 0xFE is zero");
        rd_byte(1, "R10 read 0xFF is zero");
        rd_byte(0, "R10 wrap to status");
        bus_stop();

        // write across the end of the bank
        bus_start();
        dev_byte(8'h90, 1, "R2 write address ack");
        ptr_byte(8'(NUM_REGS - 2));
        wr_byte(8'h61, "R5 second to last reg");
        wr_byte(8'h71, "R5 last reg");
        wr_byte(8'h81, "R6 past end acked");
        bus_stop();
        check(ctrl_o == model_ctrl(), "R6 bank after end write", ctrl_o, model_ctrl());

        // fill every writable register, then read all back
        bus_start();
        dev_byte(8'h90, 1, "R2 write address ack");
        ptr_byte(8'h01);
        for (int k = 1; k < NUM_REGS; k++) wr_byte(8'(8'h10 * k + k), "R5 fill");
        bus_stop();
        bus_start();
        dev_byte(8'h91, 1, "R2 read address ack");
        for (int k = 0; k < NUM_REGS; k++) rd_byte(k != NUM_REGS - 1, "R7 read-back");
        bus_stop();

        check(oe_hi_moves == 0, "R11 enable moved with SCL high", oe_hi_moves, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule